// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It follows the standard sixteen-state test access port sequence, driven by the test mode select line on each rising edge of the test clock. It holds a three-bit instruction, decodes it, and routes one data register between the serial input and the serial output. The block contains a one-stage bypass register and a 32-bit identification register. The chip's boundary register sits outside the block: the block gives it capture, shift and update strobes and takes back its serial output.

Two instructions also drive mode outputs. One mode lets the boundary cells drive the pins. The other holds the pins at their preloaded values while the scan path goes through the bypass stage. The serial output changes on the falling edge of the test clock, and its enable is high only while a shift state is active. A hold input can lock the whole port in reset, so that the test logic stays inactive during normal operation.

Top module: `tap_ctrl_top`

## Requirements
- R1: The controller moves through the sixteen standard states on each rising `tck` edge according to `tms`. A pause in the middle of a data scan, passing through the exit and pause states and back into shift, neither loses nor changes the bits shifted.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. While it is in that state, the current instruction is set to the identification opcode 011.
- R3: When `tap_rst_n` is low, or when `tap_hold` is high, the controller enters Test-Logic-Reset at the next rising edge and the current instruction becomes 011. While either is active, `tdo_oe` stays 0.
- R4: When the instruction path passes through its capture state, the instruction shift stage loads 001. That stage shifts from `tdi` with the least significant bit leaving first. The current instruction changes only on the rising edge that leaves Update-IR.
- R5: Opcode decode: 111 is bypass, 001 drives the pins from the boundary register, 100 samples or preloads the boundary register, 010 clamps, and 011 selects identification. The unlisted codes 000, 101 and 110 act as bypass.
- R6: The bypass stage loads 0 on capture and is one bit long. It is the scan path for bypass, clamp and the unlisted codes, so an 8-bit scan of pattern P returns {P[6:0],0}.
- R7: Under the identification opcode, capture loads 0x301F002B (version 3, part field 0x01F0, maker field 0x015, bit 0 set to 1), and the value shifts out least significant bit first.
- R8: `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR only under opcodes 001 and 100. Under those opcodes, `tdo` carries `bsr_tdo`.
- R9: `extest_mode` is high exactly while the current instruction is 001, and `clamp_mode` exactly while it is 010. Both persist across data scans and across the shifting of a new instruction until the next update or reset.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only after the controller has entered Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Active-low test port reset |
| tap_hold | input | 1 | When 1, holds the port in reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data input |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Boundary register capture strobe |
| bsr_shift | output | 1 | Boundary register shift strobe |
| bsr_update | output | 1 | Boundary register update strobe |
| extest_mode | output | 1 | Boundary cells drive the pins |
| clamp_mode | output | 1 | Pins held at their preloaded values, bypass path selected |

## Verification
The assertions check on every cycle that reset or hold returns the controller to Test-Logic-Reset, and that five high `tms` edges do the same. They also check the capture pattern, that the instruction stays unchanged outside Update-IR and reset, that the boundary strobes appear only under the two boundary opcodes, that the output enable appears only in shift states, and that a mode rises only just after Update-IR. Other behaviours can only be shown by the bench's scenarios: the scan results for all eight opcodes, the exact identification value, the one-cycle bypass delay, data integrity across a pause, and the half-cycle retiming of the output.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W            = 3;
    localparam int TLR_TMS_COUNT   = 5;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b001;
    localparam logic [IR_W-1:0] OP_CLAMP  = 3'b010;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b011;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_BSR,
        PATH_ID
    } path_e;

    typedef struct packed {
        path_e path;
        logic  extest;
        logic  clamp;
    } decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic decode_t decode_op(input logic [IR_W-1:0] op);
        decode_t d;
        d.path   = PATH_BYP;
        d.extest = 1'b0;
        d.clamp  = 1'b0;
        case (op)
            OP_EXTEST: begin
                d.path   = PATH_BSR;
                d.extest = 1'b1;
            end
            OP_SAMPLE: d.path = PATH_BSR;
            OP_IDCODE: d.path = PATH_ID;
            OP_CLAMP:  d.clamp = 1'b1;
            default:   d.path = PATH_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_q;

    always_ff @(posedge tck) begin
        if (rst) state_q <= ST_RESET;
        else     state_q <= tap_next(state_q, tms);
    end

    assign state = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter logic [IR_W-1:0] CAPTURE_PAT = 3'b001,
    parameter logic [IR_W-1:0] RESET_OP    = OP_IDCODE
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_cur,
    output decode_t         dec
);

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] cur_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            sh_q <= CAPTURE_PAT;
        end else begin
            case (state)
                ST_CAP_IR: sh_q <= CAPTURE_PAT;
                ST_SH_IR:  sh_q <= {tdi, sh_q[IR_W-1:1]};
                default:   sh_q <= sh_q;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) cur_q <= RESET_OP;
        else if (state == ST_UPD_IR)  cur_q <= sh_q;
    end

    assign ir_shift = sh_q;
    assign ir_cur   = cur_q;
    assign dec      = decode_op(cur_q);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h301F_002B
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  path_e      path,
    input  logic       tdi,
    input  logic       bsr_tdo,
    output logic       dr_tdo
);

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            id_sel;

    assign id_sel = (path == PATH_ID);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else begin
            case (state)
                ST_CAP_DR: byp_q <= 1'b0;
                ST_SH_DR:  byp_q <= tdi;
                default:   byp_q <= byp_q;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            id_q <= ID_VALUE;
        end else if (id_sel) begin
            case (state)
                ST_CAP_DR: id_q <= ID_VALUE;
                ST_SH_DR:  id_q <= {tdi, id_q[ID_W-1:1]};
                default:   id_q <= id_q;
            endcase
        end
    end

    always_comb begin
        case (path)
            PATH_BSR: dr_tdo = bsr_tdo;
            PATH_ID:  dr_tdo = id_q[0];
            default:  dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_ctrl_top.sv
module tap_ctrl_top
    import tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'h01F0,
    parameter logic [10:0] ID_MAKER   = 11'h015,
    parameter logic [IR_W-1:0] IR_CAPTURE = 3'b001
) (
    input  logic tck,
    input  logic tap_rst_n,
    input  logic tap_hold,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_tdo,
    output logic tdo,
    output logic tdo_oe,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic extest_mode,
    output logic clamp_mode
);

    localparam int              ID_W    = 4 + 16 + 11 + 1;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    logic            tap_rst;
    tap_state_e      st;
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_cur;
    decode_t         dec;
    logic            dr_out;
    logic            in_sh_ir;
    logic            in_sh_dr;
    logic            bsr_path;
    logic            tdo_q;
    logic            oe_q;

    assign tap_rst = ~tap_rst_n | tap_hold;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (tap_rst),
        .tms   (tms),
        .state (st)
    );

    tap_ir #(
        .CAPTURE_PAT (IR_CAPTURE),
        .RESET_OP    (OP_IDCODE)
    ) u_ir (
        .tck      (tck),
        .rst      (tap_rst),
        .state    (st),
        .tdi      (tdi),
        .ir_shift (ir_sh),
        .ir_cur   (ir_cur),
        .dec      (dec)
    );

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_WORD)
    ) u_dr (
        .tck     (tck),
        .rst     (tap_rst),
        .state   (st),
        .path    (dec.path),
        .tdi     (tdi),
        .bsr_tdo (bsr_tdo),
        .dr_tdo  (dr_out)
    );

    assign in_sh_ir = (st == ST_SH_IR);
    assign in_sh_dr = (st == ST_SH_DR);
    assign bsr_path = (dec.path == PATH_BSR);

    assign bsr_capture = bsr_path && (st == ST_CAP_DR);
    assign bsr_shift   = bsr_path && in_sh_dr;
    assign bsr_update  = bsr_path && (st == ST_UPD_DR);
    assign extest_mode = dec.extest;
    assign clamp_mode  = dec.clamp;

    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= in_sh_ir | in_sh_dr;
            tdo_q <= in_sh_ir ? ir_sh[0] : dr_out;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            rst,
    input logic            tap_rst_n,
    input logic            tap_hold,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sh,
    input logic [IR_W-1:0] ir_cur,
    input logic            tdo_oe,
    input logic            bsr_capture,
    input logic            bsr_shift,
    input logic            bsr_update,
    input logic            extest_mode,
    input logic            clamp_mode
);

    logic [2:0] hi_cnt;

    always_ff @(posedge tck) begin
        if (rst)                        hi_cnt <= 3'd0;
        else if (!tms)                  hi_cnt <= 3'd0;
        else if (hi_cnt < TLR_TMS_COUNT) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r3_reset_to_tlr: assert property (@(posedge tck)
        (!tap_rst_n || tap_hold) |=> (state == ST_RESET && ir_cur == OP_IDCODE));

    a_r2_tms_five: assert property (@(posedge tck) disable iff (rst)
        (hi_cnt == TLR_TMS_COUNT) |-> (state == ST_RESET));

    a_r4_capture_pattern: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_IR) |=> (ir_sh == 3'b001));

    a_r4_hold_instr: assert property (@(posedge tck) disable iff (rst)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_cur));

    a_r8_strobes_boundary: assert property (@(posedge tck) disable iff (rst)
        (bsr_capture || bsr_shift || bsr_update) |-> (ir_cur == OP_EXTEST || ir_cur == OP_SAMPLE));

    a_r9_mode_rise: assert property (@(posedge tck) disable iff (rst)
        ($rose(extest_mode) || $rose(clamp_mode)) |-> ($past(state) == ST_UPD_IR));

    a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind tap_ctrl_top tap_ctrl_chk u_chk (
    .tck         (tck),
    .rst         (tap_rst),
    .tap_rst_n   (tap_rst_n),
    .tap_hold    (tap_hold),
    .tms         (tms),
    .state       (st),
    .ir_sh       (ir_sh),
    .ir_cur      (ir_cur),
    .tdo_oe      (tdo_oe),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update),
    .extest_mode (extest_mode),
    .clamp_mode  (clamp_mode)
);

// File: tb/sim_tap_ctrl_top.sv
`timescale 1ns/1ps
module sim_tap_ctrl_top;

    logic tck = 1'b0;
    logic tap_rst_n, tap_hold, tms, tdi, bsr_tdo;
    logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, extest_mode, clamp_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 tck = ~tck;

    tap_ctrl_top u0 (
        .tck(tck), .tap_rst_n(tap_rst_n), .tap_hold(tap_hold), .tms(tms), .tdi(tdi),
        .bsr_tdo(bsr_tdo), .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture),
        .bsr_shift(bsr_shift), .bsr_update(bsr_update), .extest_mode(extest_mode),
        .clamp_mode(clamp_mode)
    );

    // {opcode, 8-bit scan result for pattern 0x6C with bsr_tdo=1, extest, clamp, boundary}
    localparam logic [7:0] PAT = 8'h6C;
    localparam logic [13:0] VEC [8] = '{
        {3'b000, 8'hD8, 1'b0, 1'b0, 1'b0},
        {3'b001, 8'hFF, 1'b1, 1'b0, 1'b1},
        {3'b010, 8'hD8, 1'b0, 1'b1, 1'b0},
        {3'b011, 8'h2B, 1'b0, 1'b0, 1'b0},
        {3'b100, 8'hFF, 1'b0, 1'b0, 1'b1},
        {3'b101, 8'hD8, 1'b0, 1'b0, 1'b0},
        {3'b110, 8'hD8, 1'b0, 1'b0, 1'b0},
        {3'b111, 8'hD8, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din,
                              output logic [31:0] dout, output int shcnt);
        dout  = '0;
        shcnt = 0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (bsr_shift) shcnt++;
            step(i == n - 1, din[i]);
        end
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        logic [31:0] o;
        int c;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_bits(3, {29'b0, op}, o, c);
        cap = o[2:0];
        step(1, 0);
        step(0, 0);
    endtask

    task automatic scan_dr(input logic [7:0] din, output logic [7:0] dout,
                           output logic cap_seen, output int shcnt, output logic upd_seen);
        logic [31:0] o;
        step(1, 0);
        step(0, 0);
        cap_seen = bsr_capture;
        step(0, 0);
        shift_bits(8, {24'b0, din}, o, shcnt);
        dout = o[7:0];
        step(1, 0);
        upd_seen = bsr_update;
        step(0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0]  cap;
        logic [7:0]  dout;
        logic        cs, us;
        int          sc;
        logic [31:0] w;

        tap_rst_n = 1'b0; tap_hold = 1'b0; tms = 1'b0; tdi = 1'b0; bsr_tdo = 1'b1;
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        tap_rst_n = 1'b1;
        // R3: reset state at the ports
        chk("R3 reset tdo_oe", {31'b0, tdo_oe}, 32'd0);
        chk("R3 reset extest", {31'b0, extest_mode}, 32'd0);
        chk("R3 reset clamp", {31'b0, clamp_mode}, 32'd0);
        step(0, 0);
        // R7: identification is the instruction after reset, 32 bits LSB first
        step(1, 0); step(0, 0); step(0, 0);
        shift_bits(32, 32'h0, w, sc);
        chk("R7 full id word", w, 32'h301F_002B);
        step(1, 0); step(0, 0);

        // R5 R6 R7 R8 R9 R4: opcode table
        for (int v = 0; v < 8; v++) begin
            logic [13:0] e;
            e = VEC[v];
            load_ir(e[13:11], cap);
            chk("R4 ir capture 001", {29'b0, cap}, 32'd1);
            chk("R9 extest_mode", {31'b0, extest_mode}, {31'b0, e[2]});
            chk("R9 clamp_mode", {31'b0, clamp_mode}, {31'b0, e[1]});
            scan_dr(PAT, dout, cs, sc, us);
            chk("R5 scan path result", {24'b0, dout}, {24'b0, e[10:3]});
            chk("R8 capture strobe", {31'b0, cs}, {31'b0, e[0]});
            chk("R8 shift strobe count", sc, e[0] ? 32'd8 : 32'd0);
            chk("R8 update strobe", {31'b0, us}, {31'b0, e[0]});
        end

        // R6: bypass with a second pattern
        load_ir(3'b111, cap);
        scan_dr(8'hA3, dout, cs, sc, us);
        chk("R6 bypass one-stage delay", {24'b0, dout}, 32'h46);

        // R8 R9: boundary data routed, mode persists across scans and IR shift
        load_ir(3'b001, cap);
        bsr_tdo = 1'b0;
        scan_dr(8'hFF, dout, cs, sc, us);
        chk("R8 tdo follows bsr_tdo", {24'b0, dout}, 32'h00);
        chk("R9 extest after data scan", {31'b0, extest_mode}, 32'd1);
        bsr_tdo = 1'b1;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_bits(3, 32'h7, w, sc);
        chk("R9 extest held before update", {31'b0, extest_mode}, 32'd1);
        step(1, 0);
        chk("R4 extest held in Update-IR", {31'b0, extest_mode}, 32'd1);
        step(0, 0);
        chk("R9 extest cleared after update", {31'b0, extest_mode}, 32'd0);

        // R10: output enable changes on the falling edge only
        step(1, 0); step(0, 0);
        tms = 1'b0;
        @(posedge tck); #1;
        chk("R10 oe still low after rising edge", {31'b0, tdo_oe}, 32'd0);
        @(negedge tck); #1;
        chk("R10 oe high after falling edge", {31'b0, tdo_oe}, 32'd1);
        step(1, 0);
        chk("R10 oe low in exit", {31'b0, tdo_oe}, 32'd0);
        step(1, 0); step(0, 0);

        // R1: pause in the middle of an identification scan
        load_ir(3'b011, cap);
        step(1, 0); step(0, 0); step(0, 0);
        shift_bits(4, 32'h0, w, sc);
        dout[3:0] = w[3:0];
        step(0, 0);
        chk("R1 oe low in pause", {31'b0, tdo_oe}, 32'd0);
        step(1, 0); step(0, 0);
        shift_bits(4, 32'h0, w, sc);
        dout[7:4] = w[3:0];
        chk("R1 data kept across pause", {24'b0, dout}, 32'h2B);
        step(1, 0); step(0, 0);

        // R2: five tms-high clocks reset from Shift-DR
        load_ir(3'b010, cap);
        chk("R2 clamp loaded", {31'b0, clamp_mode}, 32'd1);
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        chk("R2 clamp cleared by tms reset", {31'b0, clamp_mode}, 32'd0);
        scan_dr(PAT, dout, cs, sc, us);
        chk("R2 identification after tms reset", {24'b0, dout}, 32'h2B);

        // R3: hold input keeps the port in reset
        load_ir(3'b001, cap);
        tap_hold = 1'b1;
        sc = 0;
        step(0, 0); step(1, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            if (tdo_oe) sc++;
            step(0, 1);
        end
        chk("R3 oe stays low under hold", sc, 32'd0);
        chk("R3 extest cleared by hold", {31'b0, extest_mode}, 32'd0);
        tap_hold = 1'b0;
        step(0, 0);
        scan_dr(PAT, dout, cs, sc, us);
        chk("R3 identification after hold", {24'b0, dout}, 32'h2B);

        // R3: active-low reset mid-scan
        load_ir(3'b100, cap);
        step(1, 0); step(0, 0); step(0, 0);
        tap_rst_n = 1'b0;
        step(0, 0);
        chk("R3 oe low under reset", {31'b0, tdo_oe}, 32'd0);
        tap_rst_n = 1'b1;
        step(0, 0);
        scan_dr(PAT, dout, cs, sc, us);
        chk("R3 no boundary strobes after reset", sc, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule